// File: doc/BRIEF.md
# UART FIFO Trigger Interrupt Controller

This block raises the three FIFO-driven interrupt requests of a UART whose transmit and receive FIFOs each hold 128 characters. The FIFO storage, the serial shifters and the baud generator sit outside the block. It receives their occupancy counts, a strobe for each character that arrives, a strobe for each read of the receive holding register, a strobe for each write into the transmit FIFO, and a tick once per character time. From these it drives a receive-data interrupt, a receive time-out interrupt and a transmit-threshold interrupt.

Software reaches the block through two write ports. The control write carries the FIFO-enable bit, a 2-bit receive trigger code and a 2-bit transmit trigger code. The mode write carries the enhanced-mode bit. The receive trigger applies as soon as it is written. A written transmit trigger is kept in storage, but the transmitter uses it only while enhanced mode is on. At all other times, including after reset, the transmit threshold is 16 characters.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset, all three interrupt outputs are low, the FIFOs are disabled, enhanced mode is off and the transmit threshold is 16.
- R2: While the FIFO-enable bit is 0, all three interrupt outputs are low, beginning in the cycle after the control write that clears the bit.
- R3: The receive trigger code maps 0→8, 1→16, 2→24 and 3→28 characters. irq_rx_data is high exactly when the FIFOs are enabled and rx_count is greater than or equal to the selected level.
- R4: The transmit trigger code uses the same mapping as R3. The transmit threshold equals the mapped code only while the enhanced bit is 1; otherwise it is 16.
- R5: A transmit code written while enhanced mode is off is kept in storage. It takes effect once the enhanced bit is later set, with no second write needed.
- R6: irq_tx_thresh is high while the interrupt is armed and tx_count is less than or equal to the transmit threshold. A tx_write pulse disarms it from the next cycle on. It re-arms in the cycle after tx_count is seen above the threshold. Reset leaves it armed.
- R7: Any received-character pulse or receive-holding-register read restarts the time-out count at zero. The count is also held at zero while rx_count is 0.
- R8: irq_rx_timeout rises on the fourth char_tick that arrives with no restart in between, provided rx_count is nonzero and below the receive level at that tick.
- R9: irq_rx_timeout stays high until a receive-holding-register read. It is low in the cycle after the read.
- R10: No time-out fires while the receive FIFO is empty or at or above its trigger level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_fifo_en | input | 1 | FIFO enable bit of the control write |
| ctl_rx_code | input | 2 | Receive trigger code of the control write |
| ctl_tx_code | input | 2 | Transmit trigger code of the control write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_enh | input | 1 | Enhanced-mode bit of the mode write |
| rx_count | input | 8 | Receive FIFO occupancy |
| tx_count | input | 8 | Transmit FIFO occupancy |
| rx_char | input | 1 | One-cycle pulse per received character |
| rx_read | input | 1 | One-cycle pulse per receive holding register read |
| tx_write | input | 1 | One-cycle pulse per transmit FIFO write |
| char_tick | input | 1 | One-cycle pulse per character time |
| irq_rx_data | output | 1 | Receive level reached |
| irq_rx_timeout | output | 1 | Receive time-out |
| irq_tx_thresh | output | 1 | Transmit FIFO at or below threshold |

## Verification
The hardest situation to reach is a transmit code that was written while enhanced mode was off and that only later becomes the active threshold. To get there, the stimulus writes code 3 with the enhanced bit clear and confirms that the 16-character threshold still governs. It then sets the enhanced bit alone and moves tx_count across 20, which lies between the old and new thresholds. The time-out path is pushed to its edge as well: a character pulse arrives on the cycle after the third tick, so the bench can see that the count restarts and that the time-out fires only on the fourth tick after that pulse.

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl #(
  parameter int DEPTH    = 128,
  parameter int TO_TICKS = 4,
  parameter int TX_RESET_LEVEL = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TO_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_fifo_en,
  input  logic [1:0]    ctl_rx_code,
  input  logic [1:0]    ctl_tx_code,
  input  logic          mode_wr,
  input  logic          mode_enh,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_char,
  input  logic          rx_read,
  input  logic          tx_write,
  input  logic          char_tick,
  output logic          irq_rx_data,
  output logic          irq_rx_timeout,
  output logic          irq_tx_thresh
);

  function automatic logic [CW-1:0] code_level(input logic [1:0] c);
    case (c)
      2'd0:    return CW'(8);
      2'd1:    return CW'(16);
      2'd2:    return CW'(24);
      default: return CW'(28);
    endcase
  endfunction

  logic          fifo_en_q, enh_q, tx_armed_q, to_flag_q;
  logic [1:0]    rx_code_q, tx_code_q;
  logic [TW-1:0] to_cnt_q;
  logic [CW-1:0] rx_level, tx_level;
  logic          rx_below, to_restart;

  assign rx_level   = code_level(rx_code_q);
  assign tx_level   = enh_q ? code_level(tx_code_q) : CW'(TX_RESET_LEVEL);
  assign rx_below   = (rx_count != '0) && (rx_count < rx_level);
  assign to_restart = !fifo_en_q || rx_count == '0 || rx_char || rx_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      rx_code_q <= 2'd0;
      tx_code_q <= 2'd1;
      enh_q     <= 1'b0;
    end else begin
      if (ctl_wr) begin
        fifo_en_q <= ctl_fifo_en;
        rx_code_q <= ctl_rx_code;
        tx_code_q <= ctl_tx_code;
      end
      if (mode_wr) enh_q <= mode_enh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        to_cnt_q <= '0;
    else if (to_restart)               to_cnt_q <= '0;
    else if (char_tick && to_cnt_q != TW'(TO_TICKS))
                                       to_cnt_q <= to_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        to_flag_q <= 1'b0;
    else if (!fifo_en_q || rx_read)    to_flag_q <= 1'b0;
    else if (!to_restart && char_tick && rx_below && to_cnt_q == TW'(TO_TICKS - 1))
                                       to_flag_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tx_armed_q <= 1'b1;
    else if (tx_write)                 tx_armed_q <= 1'b0;
    else if (tx_count > tx_level)      tx_armed_q <= 1'b1;
  end

  assign irq_rx_data    = fifo_en_q && (rx_count >= rx_level);
  assign irq_rx_timeout = fifo_en_q && to_flag_q;
  assign irq_tx_thresh  = fifo_en_q && tx_armed_q && (tx_count <= tx_level);

endmodule

module uart_fifo_irq_ctrl_chk #(
  parameter int CW = 8,
  parameter int TX_RESET_LEVEL = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic          ctl_fifo_en,
  input logic          enh_q,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_read,
  input logic          tx_write,
  input logic          char_tick,
  input logic          irq_rx_data,
  input logic          irq_rx_timeout,
  input logic          irq_tx_thresh
);

  a_r2_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr && !ctl_fifo_en) |-> !(irq_rx_data || irq_rx_timeout || irq_tx_thresh));

  a_r3_min_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_data |-> rx_count >= CW'(8));

  a_r4_legacy_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_q && irq_tx_thresh) |-> tx_count <= CW'(TX_RESET_LEVEL));

  a_r6_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> !irq_tx_thresh);

  a_r8_fires_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx_timeout) |-> $past(char_tick));

  a_r10_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx_timeout) |-> $past(rx_count) != '0);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |=> !irq_rx_timeout);

endmodule

bind uart_fifo_irq_ctrl uart_fifo_irq_ctrl_chk #(.CW(CW), .TX_RESET_LEVEL(TX_RESET_LEVEL)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_fifo_en(ctl_fifo_en), .enh_q(enh_q),
  .rx_count(rx_count), .tx_count(tx_count), .rx_read(rx_read), .tx_write(tx_write),
  .char_tick(char_tick), .irq_rx_data(irq_rx_data), .irq_rx_timeout(irq_rx_timeout),
  .irq_tx_thresh(irq_tx_thresh)
);

// File: tb/uart_fifo_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_irq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_fifo_en = 0, mode_wr = 0, mode_enh = 0;
  logic [1:0] ctl_rx_code = 0, ctl_tx_code = 0;
  logic [7:0] rx_count = 0, tx_count = 0;
  logic rx_char = 0, rx_read = 0, tx_write = 0, char_tick = 0;
  logic irq_rx_data, irq_rx_timeout, irq_tx_thresh;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_fifo_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_fifo_en(ctl_fifo_en),
    .ctl_rx_code(ctl_rx_code), .ctl_tx_code(ctl_tx_code), .mode_wr(mode_wr),
    .mode_enh(mode_enh), .rx_count(rx_count), .tx_count(tx_count), .rx_char(rx_char),
    .rx_read(rx_read), .tx_write(tx_write), .char_tick(char_tick),
    .irq_rx_data(irq_rx_data), .irq_rx_timeout(irq_rx_timeout), .irq_tx_thresh(irq_tx_thresh));

  // behavioural reference
  int m_en, m_rxc, m_txc, m_enh, m_idle, m_to, m_arm;
  function automatic int lvl(input int c);
    int t[4] = '{8, 16, 24, 28};
    return t[c];
  endfunction
  function automatic int m_txl();
    return m_enh != 0 ? lvl(m_txc) : 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_rxc = 0; m_txc = 1; m_enh = 0; m_idle = 0; m_to = 0; m_arm = 1;
    end else begin
      int txl, rxl, en_old;
      txl = m_txl(); rxl = lvl(m_rxc); en_old = m_en;
      if (tx_write) m_arm = 0; else if (int'(tx_count) > txl) m_arm = 1;
      if (en_old == 0 || rx_read) m_to = 0;
      else if (!(rx_count == 0 || rx_char) && char_tick && m_idle == 3 &&
               rx_count != 0 && int'(rx_count) < rxl) m_to = 1;
      if (en_old == 0 || rx_count == 0 || rx_char || rx_read) m_idle = 0;
      else if (char_tick && m_idle < 4) m_idle++;
      if (ctl_wr) begin m_en = ctl_fifo_en; m_rxc = ctl_rx_code; m_txc = ctl_tx_code; end
      if (mode_wr) m_enh = mode_enh;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 model rx_data", irq_rx_data, m_en != 0 && int'(rx_count) >= lvl(m_rxc));
    chk("R8 model timeout", irq_rx_timeout, m_en != 0 && m_to != 0);
    chk("R6 model tx", irq_tx_thresh, m_en != 0 && m_arm != 0 && int'(tx_count) <= m_txl());
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic ctl(input logic en, input logic [1:0] rc, input logic [1:0] tc);
    ctl_wr = 1; ctl_fifo_en = en; ctl_rx_code = rc; ctl_tx_code = tc; step(1); ctl_wr = 0;
  endtask
  task automatic mode(input logic e);
    mode_wr = 1; mode_enh = e; step(1); mode_wr = 0;
  endtask
  task automatic pulse_tick();  char_tick = 1; step(1); char_tick = 0; endtask
  task automatic pulse_char();  rx_char = 1;   step(1); rx_char = 0;   endtask
  task automatic pulse_read();  rx_read = 1;   step(1); rx_read = 0;   endtask
  task automatic pulse_txw();   tx_write = 1;  step(1); tx_write = 0;  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3); rst_n = 1; step(1);
    chk("R1 rx_data reset", irq_rx_data, 0);
    chk("R1 timeout reset", irq_rx_timeout, 0);
    chk("R1 tx reset", irq_tx_thresh, 0);

    // R4: enhanced off, code 3 written, level stays 16
    tx_count = 20; ctl(1, 2'd0, 2'd3); step(1);
    chk("R4 tx 20 above 16", irq_tx_thresh, 0);
    tx_count = 16; step(1);
    chk("R4 tx 16 at level", irq_tx_thresh, 1);
    pulse_txw();
    chk("R6 write disarms", irq_tx_thresh, 0);
    step(2);
    chk("R6 stays disarmed", irq_tx_thresh, 0);
    tx_count = 17; step(1); tx_count = 10; step(1);
    chk("R6 rearmed", irq_tx_thresh, 1);
    // R5: enhanced set later, stored code 3 -> 28
    tx_count = 30; step(1); tx_count = 20; step(1);
    chk("R5 before enh", irq_tx_thresh, 0);
    mode(1); step(1);
    chk("R5 enh applies 28", irq_tx_thresh, 1);
    ctl(1, 2'd0, 2'd0); tx_count = 9; step(1); tx_count = 8; step(1);
    chk("R4 code0 level 8", irq_tx_thresh, 1);

    // R3 receive levels
    ctl(1, 2'd1, 2'd0);
    rx_count = 15; step(1); chk("R3 15 below 16", irq_rx_data, 0);
    rx_count = 16; step(1); chk("R3 16 at 16", irq_rx_data, 1);
    ctl(1, 2'd3, 2'd0); chk("R3 16 below 28", irq_rx_data, 0);
    rx_count = 28; step(1); chk("R3 28 at 28", irq_rx_data, 1);
    ctl(1, 2'd2, 2'd0); rx_count = 23; step(1); chk("R3 23 below 24", irq_rx_data, 0);
    rx_count = 24; step(1); chk("R3 24 at 24", irq_rx_data, 1);

    // time-out, level 24
    rx_count = 3; pulse_char();
    pulse_tick(); pulse_tick(); pulse_tick();
    pulse_char();
    chk("R7 restart", irq_rx_timeout, 0);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R7 3 ticks after restart", irq_rx_timeout, 0);
    pulse_tick();
    chk("R8 fires on 4th tick", irq_rx_timeout, 1);
    step(5);
    chk("R9 holds", irq_rx_timeout, 1);
    pulse_read();
    chk("R9 read clears", irq_rx_timeout, 0);
    pulse_read(); step(1);
    for (int i = 0; i < 3; i++) pulse_tick();
    pulse_read(); step(1);
    chk("R7 read restart", irq_rx_timeout, 0);

    rx_count = 0; step(1);
    for (int i = 0; i < 6; i++) pulse_tick();
    chk("R10 empty no timeout", irq_rx_timeout, 0);
    rx_count = 24; step(1);
    for (int i = 0; i < 6; i++) pulse_tick();
    chk("R10 at level no timeout", irq_rx_timeout, 0);

    // R2 disable
    rx_count = 5; step(1);
    for (int i = 0; i < 4; i++) pulse_tick();
    tx_count = 2; rx_count = 28; step(1);
    ctl(0, 2'd0, 2'd0);
    chk("R2 rx_data off", irq_rx_data, 0);
    chk("R2 timeout off", irq_rx_timeout, 0);
    chk("R2 tx off", irq_tx_thresh, 0);
    step(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule